// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block moves data between memory locations for up to 32 channels, with each channel described by a descriptor in a table in shared memory. Software programs the table base, writes a descriptor for a channel, and enables the channel through a set register. When an enabled channel also has its request input high, the engine fetches that channel's descriptor over its memory master port. It then copies the items one by one. Each address is computed backwards from an inclusive end pointer. After every item the engine writes the updated control word back into the table.

A transfer runs to completion once it has started. When the item count is used up, the control word in memory shows a zero count and the stop mode, and the engine clears the channel's enable bit itself. A descriptor whose mode is not the basic copy mode causes no data movement, and the channel is disabled as soon as that descriptor has been read. Each channel owns a 16-byte slot in the primary half of the table. The alternate half above it is reserved and never accessed.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset no channel is enabled, `busy` is low and no memory request is made.
- R2: A register write to index 1 sets the enable bit of every channel whose data bit is 1. A write to index 2 clears the enable bit of every such channel. Zero bits have no effect. Index 0 loads the table base, of which bits [31:10] are kept.
- R3: Channel c's descriptor is at base + c*16. The source end pointer is at +0, the destination end pointer at +4 and the control word at +8. They are read in that order, and nothing at base + 0x200 or above is accessed.
- R4: Control word layout: mode in [2:0] (0 = stop, 1 = basic); item count minus one in [13:4]; source size in [25:24]; source increment in [27:26]; destination size in [29:28]; destination increment in [31:30]. Size codes 0/1/2 mean 1/2/4 bytes.
- R5: Item i of N has the address end − (N−1−i)·s. The step s is 1, 2 or 4 for increment codes 0, 1 and 2. Code 3 keeps the end pointer as a fixed address for every item.
- R6: Each item is read from the source and written to the destination. The write strobes cover the destination size, starting at the lane given by the destination address bits [1:0]. The data is realigned from the source lane to the destination lane.
- R7: After each item the control word is written back, with every field except count and mode unchanged. After a non-final item the count field is one lower. After the final item the count is 0 and the mode is stop.
- R8: The engine writes only destination items and control words. End pointers and all other memory stay untouched.
- R9: When a transfer completes, the channel's enable bit clears without software action.
- R10: A descriptor whose mode is not basic produces no write at all, and the channel's enable bit is cleared.
- R11: Among channels that are both enabled and requesting, the lowest index is served first, and its whole transfer finishes before the next channel starts.
- R12: A requesting channel that is not enabled causes no memory access.
- R13: The memory request, address and direction stay constant from the cycle the request is raised until the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 base, 1 enable set, 2 enable clear |
| reg_wdata | input | 32 | Register write data |
| ch_req | input | NCH | Per-channel transfer request |
| ch_en | output | NCH | Per-channel enable state |
| busy | output | 1 | Engine is working on a channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane strobes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Most internal faults show up at the memory port on the very next access. A wrong remaining count gives a wrong address at the first item, a wrong step appears by the second item, and a wrong lane selection shows in the first write's strobes or data. A corrupted control word shows up in the first write-back after the first item, and a missed self-disable is visible on `ch_en` as soon as the engine returns to idle. Each memory write is compared against a scoreboard in order, and the full memory image is compared against a reference after each transfer, so any stray write is also caught.

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic [NCH-1:0] ch_req,
  output logic [NCH-1:0] ch_en,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [3:0]     mem_be,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_SP, S_DP, S_CW, S_RD, S_WR, S_WB} st_t;

  st_t         st;
  logic [4:0]  cur, pick;
  logic [21:0] base;
  logic [31:0] sptr, dptr, cw, data;
  logic [9:0]  rem;
  logic        stop_now;

  wire [NCH-1:0] pend = ch_en & ch_req;
  wire [31:0]    desc = {base, 1'b0, cur, 4'b0000};
  wire [31:0]    src_a = (cw[27:26] == 2'd3) ? sptr : sptr - ({22'b0, rem} << cw[27:26]);
  wire [31:0]    dst_a = (cw[31:30] == 2'd3) ? dptr : dptr - ({22'b0, rem} << cw[31:30]);
  wire           last  = (rem == 10'd0);
  wire [31:0]    cw_nx = last ? {cw[31:14], 10'd0, cw[3], 3'b000}
                              : {cw[31:14], rem - 10'd1, cw[3:0]};

  always_comb begin
    pick = 5'd0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = 5'(i);
  end

  always_comb begin
    stop_now = 1'b0;
    if (mem_ack && st == S_CW && mem_rdata[2:0] != 3'd1) stop_now = 1'b1;
    if (mem_ack && st == S_WB && last) stop_now = 1'b1;
  end

  assign busy    = (st != S_IDLE);
  assign mem_req = busy;
  assign mem_we  = (st == S_WR) || (st == S_WB);

  always_comb begin
    case (st)
      S_DP:    mem_addr = desc | 32'h4;
      S_CW:    mem_addr = desc | 32'h8;
      S_RD:    mem_addr = src_a;
      S_WR:    mem_addr = dst_a;
      S_WB:    mem_addr = desc | 32'h8;
      default: mem_addr = desc;
    endcase
  end

  always_comb begin
    mem_be = 4'hF;
    if (st == S_WR)
      case (cw[29:28])
        2'd0:    mem_be = 4'b0001 << dst_a[1:0];
        2'd1:    mem_be = 4'b0011 << dst_a[1:0];
        default: mem_be = 4'hF;
      endcase
  end

  assign mem_wdata = (st == S_WB) ? cw_nx
                   : (data >> {src_a[1:0], 3'b000}) << {dst_a[1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en <= '0;
      base  <= '0;
    end else begin
      logic [NCH-1:0] set_m, clr_m, eng_m;
      set_m = (reg_we && reg_addr == 2'd1) ? reg_wdata[NCH-1:0] : '0;
      clr_m = (reg_we && reg_addr == 2'd2) ? reg_wdata[NCH-1:0] : '0;
      eng_m = stop_now ? ({{(NCH-1){1'b0}}, 1'b1} << cur) : '0;
      ch_en <= (ch_en | set_m) & ~clr_m & ~eng_m;
      if (reg_we && reg_addr == 2'd0) base <= reg_wdata[31:10];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      sptr <= '0;
      dptr <= '0;
      cw   <= '0;
      data <= '0;
      rem  <= '0;
    end else if (st == S_IDLE) begin
      if (pend != '0) begin
        cur <= pick;
        st  <= S_SP;
      end
    end else if (mem_ack) begin
      case (st)
        S_SP: begin sptr <= mem_rdata; st <= S_DP; end
        S_DP: begin dptr <= mem_rdata; st <= S_CW; end
        S_CW: begin
          cw  <= mem_rdata;
          rem <= mem_rdata[13:4];
          st  <= (mem_rdata[2:0] == 3'd1) ? S_RD : S_IDLE;
        end
        S_RD: begin data <= mem_rdata; st <= S_WR; end
        S_WR: st <= S_WB;
        S_WB: begin
          cw <= cw_nx;
          if (last) st <= S_IDLE;
          else begin rem <= rem - 10'd1; st <= S_RD; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [1:0]     reg_addr,
  input logic [31:0]    reg_wdata,
  input logic [NCH-1:0] ch_en,
  input logic           mem_req,
  input logic           mem_we,
  input logic [31:0]    mem_addr,
  input logic [3:0]     mem_be,
  input logic [31:0]    mem_wdata,
  input logic           mem_ack,
  input logic [21:0]    tbl_base
);
  wire in_tbl = mem_addr[31:10] == tbl_base;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
  AST_PRIMARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && in_tbl |-> !mem_addr[9]); // R3
  AST_NO_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && in_tbl |-> mem_addr[3:0] == 4'h8); // R8
  AST_CW_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && in_tbl |-> mem_wdata[2:0] <= 3'd1); // R7
  AST_STROBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0); // R6
  AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd2 |=> (ch_en & $past(reg_wdata[NCH-1:0])) == '0); // R2
endmodule

bind dma_desc_engine dma_desc_engine_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ch_en(ch_en), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .tbl_base(base)
);

// File: tb/dma_desc_engine_tb_top.sv
module dma_desc_engine_tb_top;
  localparam int NCH = 32;
  localparam logic [31:0] TBL = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [NCH-1:0] ch_req = '0, ch_en;
  logic busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;

  always #10 clk = ~clk;

  dma_desc_engine #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ch_req(ch_req), .ch_en(ch_en), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] rm  [0:4095];

  typedef struct { logic [31:0] a; logic [3:0] be; logic [31:0] d; string tag; } wr_t;
  wr_t q[$];
  int checks = 0, errors = 0, wr_cnt = 0, req_seen = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      logic [11:0] w;
      w = {mem_addr[11:2], 2'b00};
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[w + 12'(b)] <= mem_wdata[8*b +: 8];
      end else
        mem_rdata <= {mem[w + 12'd3], mem[w + 12'd2], mem[w + 12'd1], mem[w]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req) req_seen++;
    if (rst_n && mem_req && mem_we && !mem_ack) begin
      logic [31:0] m;
      wr_cnt++;
      if (q.size() == 0) chk(0, "R8", "unexpected write addr", mem_addr, 32'h0);
      else begin
        wr_t e;
        e = q.pop_front();
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{e.be[b]}};
        chk(mem_addr == e.a, e.tag, "write address", mem_addr, e.a);
        chk(mem_be == e.be, e.tag, "write strobes", {28'b0, mem_be}, {28'b0, e.be});
        chk((mem_wdata & m) == (e.d & m), e.tag, "write data", mem_wdata & m, e.d & m);
      end
    end
  end

  task automatic poke32(logic [31:0] a, logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      mem[a[11:0] + 12'(b)] = v[8*b +: 8];
      rm[a[11:0] + 12'(b)]  = v[8*b +: 8];
    end
  endtask

  function automatic logic [31:0] rword(logic [31:0] a);
    logic [11:0] w;
    w = {a[11:2], 2'b00};
    return {rm[w + 12'd3], rm[w + 12'd2], rm[w + 12'd1], rm[w]};
  endfunction

  function automatic logic [31:0] mkcw(int mode, int n, int ssz, int sinc, int dsz, int dinc);
    return {2'(dinc), 2'(dsz), 2'(sinc), 2'(ssz), 10'd0, 10'(n - 1), 1'b0, 3'(mode)};
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: writes the descriptor and pushes every expected write (R4 R5 R6 R7)
  task automatic push_xfer(int ch, logic [31:0] sp, logic [31:0] dp, logic [31:0] cw);
    int n;
    logic [31:0] da, sa, v, cwa, cur;
    int ss, ds;
    n   = int'(cw[13:4]) + 1;
    ss  = (cw[27:26] == 2'd3) ? 0 : (1 << cw[27:26]);
    ds  = (cw[31:30] == 2'd3) ? 0 : (1 << cw[31:30]);
    cwa = TBL + 32'(ch * 16) + 32'h8;
    poke32(TBL + 32'(ch * 16), sp);
    poke32(TBL + 32'(ch * 16) + 32'h4, dp);
    poke32(cwa, cw);
    poke32(TBL + 32'(ch * 16) + 32'hC, 32'hDEAD_0000 | 32'(ch));
    cur = cw;
    for (int i = 0; i < n; i++) begin
      wr_t e;
      int nb;
      sa = sp - 32'((n - 1 - i) * ss);
      da = dp - 32'((n - 1 - i) * ds);
      nb = 1 << cw[29:28];
      v  = (rword(sa) >> (8 * sa[1:0])) << (8 * da[1:0]);
      e.a = da; e.be = 4'((1 << nb) - 1) << da[1:0]; e.d = v; e.tag = "R6";
      q.push_back(e);
      for (int b = 0; b < 4; b++)
        if (e.be[b]) rm[{da[11:2], 2'(b)}] = v[8*b +: 8];
      if (i == n - 1) cur = cw & 32'hFFFF_C008;
      else cur = {cw[31:14], 10'(n - 2 - i), cw[3:0]};
      e.a = cwa; e.be = 4'hF; e.d = cur; e.tag = "R7";
      q.push_back(e);
      for (int b = 0; b < 4; b++) rm[cwa[11:0] + 12'(b)] = cur[8*b +: 8];
    end
  endtask

  task automatic wait_idle(int ch);
    int t;
    t = 0;
    while (ch_en[ch] && t < 3000) begin @(negedge clk); t++; end
    ch_req[ch] = 1'b0;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic image_check(string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < 4096; i++) if (mem[i] !== rm[i] && bad < 0) bad = i;
    chk(bad < 0, tag, "memory image at index", 32'(bad), 32'hFFFF_FFFF);
    chk(q.size() == 0, tag, "scoreboard left over", 32'(q.size()), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 7 + 3);
      rm[i]  = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(ch_en == '0 && !busy && !mem_req, "R1", "reset state", {31'b0, busy | mem_req} | ch_en, 0);
    rst_n = 1'b1;
    reg_write(2'd0, TBL);

    reg_write(2'd1, 32'h0000_0005);
    chk(ch_en == 32'h5, "R2", "enable set", ch_en, 32'h5);
    reg_write(2'd2, 32'h0000_0001);
    chk(ch_en == 32'h4, "R2", "enable clear", ch_en, 32'h4);
    reg_write(2'd2, 32'h0000_0004);
    chk(ch_en == 32'h0, "R2", "enable clear all", ch_en, 32'h0);

    // R3 R5: word copy, 4 items, both sides stepping by 4
    push_xfer(3, 32'h80C, 32'hA0C, mkcw(1, 4, 2, 2, 2, 2));
    reg_write(2'd1, 32'h8); ch_req[3] = 1'b1;
    wait_idle(3);
    chk(!ch_en[3], "R9", "self disable ch3", {31'b0, ch_en[3]}, 0);
    image_check("R8");

    // R6: byte items, destination stepping by 2 on odd lanes
    push_xfer(7, 32'h824, 32'hA49, mkcw(1, 5, 0, 0, 0, 1));
    reg_write(2'd1, 32'h80); ch_req[7] = 1'b1;
    wait_idle(7);
    chk(!ch_en[7], "R9", "self disable ch7", {31'b0, ch_en[7]}, 0);
    image_check("R6");

    // R5: fixed halfword source address, destination stepping by 2
    push_xfer(0, 32'h842, 32'hA64, mkcw(1, 3, 1, 3, 1, 1));
    reg_write(2'd1, 32'h1); ch_req[0] = 1'b1;
    wait_idle(0);
    image_check("R5");

    // R10: stop mode descriptor
    poke32(TBL + 32'h20, 32'h8F0);
    poke32(TBL + 32'h24, 32'hAF0);
    poke32(TBL + 32'h28, mkcw(0, 7, 2, 2, 2, 2));
    begin
      int w0;
      w0 = wr_cnt;
      reg_write(2'd1, 32'h4); ch_req[2] = 1'b1;
      wait_idle(2);
      chk(wr_cnt == w0, "R10", "writes on stop", 32'(wr_cnt - w0), 0);
      chk(!ch_en[2], "R10", "stop disables", {31'b0, ch_en[2]}, 0);
      image_check("R10");
    end

    // R12: request without enable
    begin
      int r0;
      r0 = req_seen;
      ch_req[9] = 1'b1;
      repeat (40) @(negedge clk);
      ch_req[9] = 1'b0;
      chk(req_seen == r0, "R12", "accesses while disabled", 32'(req_seen - r0), 0);
    end

    // R11: two channels at once, lower index completes first
    push_xfer(1, 32'h884, 32'hA84, mkcw(1, 2, 2, 2, 2, 2));
    push_xfer(4, 32'h892, 32'hAA3, mkcw(1, 3, 0, 0, 0, 3));
    reg_write(2'd1, 32'h12);
    ch_req[1] = 1'b1; ch_req[4] = 1'b1;
    wait_idle(4);
    ch_req[1] = 1'b0;
    chk(ch_en == '0, "R11", "both channels done", ch_en, 0);
    image_check("R11");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule